// File: doc/BRIEF.md
# Filtered Scanline Interrupt Counter

This block counts video scanlines by watching bit 12 of the video chip's pattern-table address. When a count that software programs runs out, it pulls a CPU interrupt line low. During a scanline, raw A12 toggles several times. In the default build, a filter therefore lets a rising edge of A12 clock the counter only if A12 was low across at least two rising edges of the CPU clock phase M2. Short low pulses are rejected, such as those seen when background and sprite fetches both come from the upper pattern half.

A build-time option swaps the filter for a divider. That variant clocks the counter once for every eighth falling edge of raw A12. The CPU reaches the counter through four write-only registers, chosen by a 2-bit select:

- select 0 stores the reload value;
- select 1 clears the counter so that it reloads on the next qualified clock;
- select 2 acknowledges any pending interrupt and disables the interrupt;
- select 3 enables the interrupt.

The A12 and M2 levels are sampled on the system clock.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, irq_n_o is high, the counter is zero and the interrupt is disabled.
- R2: In the filter build, a rising edge of A12 clocks the counter when at least M2_LOW_MIN (default 2) rising edges of M2 were sampled while A12 was low since A12 last went low.
- R3: In the filter build, a rising edge of A12 that follows fewer than M2_LOW_MIN M2 rising edges with A12 low does not clock the counter.
- R4: The filter's count of M2 rising edges saturates at M2_LOW_MIN, and it returns to zero in any cycle in which A12 is sampled high. A long low period therefore yields exactly one qualified clock.
- R5: A write with select 0 stores wr_data_i as the reload value.
- R6: A write with select 1 sets the counter to zero and marks a reload pending.
- R7: On a qualified clock, a counter that is zero or has a reload pending is loaded from the reload value and the pending mark is cleared. Otherwise the counter decrements by one.
- R8: If the counter is zero after the step of a qualified clock and the interrupt is enabled, the interrupt becomes pending and irq_n_o goes low. It stays low until it is acknowledged.
- R9: A write with select 2 clears any pending interrupt and disables the interrupt. A write with select 3 enables it. While the interrupt is disabled, qualified clocks never drive irq_n_o low.
- R10: With a reload value of 0 and the interrupt enabled, every qualified clock makes the interrupt pending.
- R11: In the divider build (USE_PRESCALE=1), the counter is clocked once for every PRESCALE-th (default 8th) falling edge of raw A12. M2 plays no part in this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; A12 and M2 are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a12_i | input | 1 | Pattern-table address bit 12 level |
| m2_i | input | 1 | CPU clock phase M2 level |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_sel_i | input | 2 | Register select: 0 reload value, 1 reload request, 2 acknowledge/disable, 3 enable |
| wr_data_i | input | CNT_W | Write data (used by select 0) |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume a few things about the inputs:

- A12 and M2 hold each level for at least one system clock, so that every edge is seen once.
- A register write never coincides with a qualified clock.

The bench drives M2 pulses of three clocks high and three clocks low, and holds A12 steady across whole pulses. It issues writes only while A12 sits high between scanlines, at least four clocks after the last edge. The order in which a simultaneous write and counter step take effect is therefore never exercised.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD_VAL = 2'd0,
    SEL_RELOAD_REQ = 2'd1,
    SEL_IRQ_OFF    = 2'd2,
    SEL_IRQ_ON     = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/scnt_m2_filter.sv
// Qualifies A12 rising edges by the number of M2 rising edges seen while A12 was low.
module scnt_m2_filter #(
  parameter int M2_LOW_MIN = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic a12_i,
  input  logic m2_i,
  output logic tick_o
);
  localparam int LW = $clog2(M2_LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(M2_LOW_MIN);

  logic          a12_q, a12_d;
  logic          m2_q, m2_d;
  logic [LW-1:0] low_q, low_d;
  logic          tick_q, tick_d;
  logic          m2_rise, a12_rise;

  assign m2_rise  = m2_i & ~m2_q;
  assign a12_rise = a12_i & ~a12_q;

  always_comb begin
    a12_d  = a12_i;
    m2_d   = m2_i;
    low_d  = low_q;
    tick_d = a12_rise && (low_q == LOW_MAX);
    if (a12_i) begin
      low_d = '0;
    end else if (m2_rise && (low_q != LOW_MAX)) begin
      low_d = low_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      a12_q  <= 1'b0;
      m2_q   <= 1'b0;
      low_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      a12_q  <= a12_d;
      m2_q   <= m2_d;
      low_q  <= low_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r4_low_saturates: assert property (@(posedge clk) disable iff (!rst_sn)
    low_q <= LOW_MAX);
  a_r4_clear_on_high: assert property (@(posedge clk) disable iff (!rst_sn)
    a12_i |=> (low_q == '0));
  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_q |=> !tick_q);
  a_r3_tick_after_low: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_q |-> a12_q);

endmodule

// File: rtl/scnt_a12_divider.sv
// Divides raw A12 falling edges by PRESCALE.
module scnt_a12_divider #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic a12_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] DIV_LAST = PW'(PRESCALE - 1);

  logic          a12_q, a12_d;
  logic [PW-1:0] div_q, div_d;
  logic          tick_q, tick_d;
  logic          a12_fall;

  assign a12_fall = a12_q & ~a12_i;

  always_comb begin
    a12_d  = a12_i;
    div_d  = div_q;
    tick_d = 1'b0;
    if (a12_fall) begin
      if (div_q == DIV_LAST) begin
        div_d  = '0;
        tick_d = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      a12_q  <= 1'b0;
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      a12_q  <= a12_d;
      div_q  <= div_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r11_div_in_range: assert property (@(posedge clk) disable iff (!rst_sn)
    div_q <= DIV_LAST);
  a_r11_single_tick: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_q |=> !tick_q);
  a_r11_tick_wraps: assert property (@(posedge clk) disable iff (!rst_sn)
    tick_q |-> (div_q == '0));

endmodule

// File: rtl/scnt_core.sv
// Reload/decrement counter, interrupt enable and pending flag.
module scnt_core
  import scnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             pend_q, pend_d;
  logic             en_q, en_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] cnt_step;
  logic             wr_rld, wr_req, wr_off, wr_on;

  assign wr_rld = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_RELOAD_VAL);
  assign wr_req = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_RELOAD_REQ);
  assign wr_off = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_IRQ_OFF);
  assign wr_on  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_IRQ_ON);

  always_comb begin
    if ((cnt_q == '0) || pend_q) begin
      cnt_step = rld_q;
    end else begin
      cnt_step = cnt_q - 1'b1;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    pend_d = pend_q;
    en_d   = en_q;
    irq_d  = irq_q;
    if (tick_i) begin
      cnt_d  = cnt_step;
      pend_d = 1'b0;
      if ((cnt_step == '0) && en_q) begin
        irq_d = 1'b1;
      end
    end
    if (wr_rld) begin
      rld_d = wr_data_i;
    end
    if (wr_req) begin
      cnt_d  = '0;
      pend_d = 1'b1;
    end
    if (wr_off) begin
      en_d  = 1'b0;
      irq_d = 1'b0;
    end
    if (wr_on) begin
      en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_q && !wr_off) |=> irq_q);
  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_off |=> (!irq_q && !en_q));
  a_r8_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq_q) |-> ((cnt_q == '0) && en_q));
  a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq_q) |-> $past(tick_i));
  a_r6_request_zeroes: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_req && !tick_i) |=> ((cnt_q == '0) && pend_q));

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit #(
  parameter bit USE_PRESCALE = 1'b0,
  parameter int CNT_W        = 8,
  parameter int M2_LOW_MIN   = 2,
  parameter int PRESCALE     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a12_i,
  input  logic             m2_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_n_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       tick;
  logic       irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[1];

  generate
    if (USE_PRESCALE) begin : g_div
      scnt_a12_divider #(.PRESCALE(PRESCALE)) u_div (
        .clk    (clk),
        .rst_sn (rst_sn),
        .a12_i  (a12_i),
        .tick_o (tick)
      );
    end else begin : g_filt
      scnt_m2_filter #(.M2_LOW_MIN(M2_LOW_MIN)) u_filt (
        .clk    (clk),
        .rst_sn (rst_sn),
        .a12_i  (a12_i),
        .m2_i   (m2_i),
        .tick_o (tick)
      );
    end
  endgenerate

  scnt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq)
  );

  assign irq_n_o = ~irq;

  a_r1_reset_idle: assert property (@(posedge clk)
    (!rst_sn) |-> irq_n_o);

endmodule

// File: tb/scanline_irq_unit_tb.sv
module scanline_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a12 = 1'b1;
  logic       m2 = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_n_f, irq_n_p;

  int checks = 0;
  int fails = 0;

  // model state, index 0 = filter build, 1 = divider build
  int m_cnt[2], m_rld[2], m_falls;
  bit m_pend[2], m_en[2], m_irq[2];

  always #5 clk = ~clk;

  scanline_irq_unit #(.USE_PRESCALE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .a12_i(a12), .m2_i(m2), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_n_o(irq_n_f));

  scanline_irq_unit #(.USE_PRESCALE(1'b1)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .a12_i(a12), .m2_i(m2), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_n_o(irq_n_p));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq_n actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_both(input string tag);
    check({tag, " filter"}, irq_n_f, ~m_irq[0]);
    check({tag, " divider"}, irq_n_p, ~m_irq[1]);
  endtask

  task automatic mclock(input int i);
    if (m_cnt[i] == 0 || m_pend[i]) begin
      m_cnt[i] = m_rld[i];
      m_pend[i] = 1'b0;
    end else begin
      m_cnt[i] = m_cnt[i] - 1;
    end
    if (m_cnt[i] == 0 && m_en[i]) m_irq[i] = 1'b1;
  endtask

  task automatic mfall();
    m_falls++;
    if (m_falls == 8) begin
      m_falls = 0;
      mclock(1);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      case (sel)
        2'd0: m_rld[i] = d;
        2'd1: begin m_cnt[i] = 0; m_pend[i] = 1'b1; end
        2'd2: begin m_en[i] = 1'b0; m_irq[i] = 1'b0; end
        default: m_en[i] = 1'b1;
      endcase
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic m2_pulse();
    m2 = 1'b1; repeat (3) @(negedge clk);
    m2 = 1'b0; repeat (3) @(negedge clk);
  endtask

  // glitches: short low pulses spanning one M2 rise; then a low span of `lows` M2 rises
  task automatic line(input int lows, input int glitches);
    for (int g = 0; g < glitches; g++) begin
      a12 = 1'b0; mfall();
      m2_pulse();
      a12 = 1'b1; repeat (2) @(negedge clk);
    end
    a12 = 1'b0; mfall();
    for (int k = 0; k < lows; k++) m2_pulse();
    a12 = 1'b1;
    if (lows >= 2) mclock(0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0; m_pend[i] = 0; m_en[i] = 0; m_irq[i] = 0;
    end
    m_falls = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_both("R1 reset");

    // R9: disabled, reload 0: qualified clocks must not raise irq
    wr(2'd0, 8'd0);
    for (int l = 0; l < 10; l++) begin
      line(3, 1);
      check_both("R9 disabled");
    end

    // sweep of reload values and line shapes (R2 R5 R6 R7 R8 R11)
    for (int rv = 0; rv < 6; rv++) begin
      wr(2'd0, 8'(rv));
      wr(2'd1, 8'd0);
      wr(2'd3, 8'd0);
      for (int l = 0; l < 12; l++) begin
        line(2 + (l % 3), l % 4);
        check_both(rv == 0 ? "R10 zero reload" : "R7 R8 count");
        if (m_irq[0] || m_irq[1]) begin
          line(2, 0);
          check_both("R8 hold");
          wr(2'd2, 8'd0);
          check_both("R9 ack");
          wr(2'd3, 8'd0);
        end
      end
    end

    // R3: only short lows; filter must never clock
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'd0);
    for (int l = 0; l < 6; l++) begin
      line(1, 3);
      check_both("R3 glitch");
    end
    line(2, 0);
    check_both("R2 qualified");

    // R4: long low gives one clock, followed by rejected glitches
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'd0);
    for (int l = 0; l < 8; l++) begin
      line(20, 2);
      check_both("R4 saturate");
      if (m_irq[0] || m_irq[1]) begin
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd0);
        check_both("R9 re-enable");
      end
    end

    // R6: reload request mid-count restarts the countdown
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd0);
    line(2, 0);
    line(2, 0);
    wr(2'd1, 8'd0);
    for (int l = 0; l < 5; l++) begin
      line(2, 0);
      check_both("R6 restart");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule